// File: doc/BRIEF.md
# Two-Tier Interrupt Aggregator

This block collects fifteen interrupt events into one request line for a processor that has a single fixed interrupt vector. Three core sources are held in a main control register and need only their own enable plus the global enable to raise the request. The twelve peripheral sources sit in two flag banks with matching enable banks. A peripheral source passes its own enable, then a group enable shared by all peripherals, and then the global enable. Every source sets its flag when its event arrives, whether or not it is enabled. Software finds the cause of an interrupt by polling the flags and clears a flag by writing 0 to it.

The global enable is held by a small state machine with three states. DISARMED is the reset state and is also entered when software writes 0. ARMED is entered when software writes 1, or on a return pulse. IN_HANDLER is entered on an "interrupt taken" pulse. The request output is high only in ARMED. Named transitions:
- ARM_BY_WRITE: DISARMED or IN_HANDLER to ARMED, on a control write with the global bit set.
- DISARM_BY_WRITE: ARMED to DISARMED, on a control write with the global bit clear.
- TAKE: any state to IN_HANDLER, on `irq_taken`.
- RETURN: any state to ARMED, on `irq_return` when `irq_taken` is low.

A write of 0 to the global bit while in IN_HANDLER leaves the state in IN_HANDLER.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every flag, every enable, the group enable and the global enable read 0, and `irq_req` is 0.
- R2: A high `src_evt[i]` at a clock edge sets that source's flag, whether or not the source is enabled. Source bits map as follows: bits 2:0 are the core sources; bit 3+p is peripheral p, which is bit p%8 of bank p/8.
- R3: A register write loads the written flag values. Writing 0 clears a flag and writing 1 sets it.
- R4: If a source event and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.
- R5: A core source drives `irq_req` high when its flag, its enable and the global enable are all 1. This is independent of the group enable.
- R6: A peripheral source drives `irq_req` high only when its flag, its own enable, the group enable and the global enable are all 1.
- R7: A pulse on `irq_taken` clears the global enable (state IN_HANDLER). `irq_req` then drops in the next cycle, and all flags are kept.
- R8: A pulse on `irq_return` sets the global enable (state ARMED), so a request that is still pending reasserts.
- R9: When `irq_taken` and `irq_return` are high in the same cycle, taken wins and the global enable ends up 0.
- R10: The register map is as follows. Address 0 is control: bits 2:0 are core flags, bits 5:3 are core enables, bit 6 is the group enable and bit 7 is the global enable. Address 1 is flag bank 0 and address 2 is flag bank 1. Address 3 is enable bank 0 and address 4 is enable bank 1. In bank 1, bits 7:4 always read 0. Addresses 5 to 7 read 0, and writes to them change nothing.
- R11: A control write with bit 7 set arms the global enable (ARM_BY_WRITE). A control write with bit 7 clear disarms it (DISARM_BY_WRITE).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 15 | Per-source event pulses |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_taken | input | 1 | Processor has taken the interrupt |
| irq_return | input | 1 | Processor returns from the handler |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is the same-cycle collision between a source event and a software clear of that flag. The bench drives the event pulse and the control write on the same falling edge, so both land on one rising edge. It then reads the flag back.

The second hard case is `irq_taken` and `irq_return` arriving together. The bench asserts both in one cycle. It then observes the global bit and `irq_req` to confirm the handler state.

Peripheral gating is walked one layer at a time, with a single flag held pending while each enable in the chain is toggled.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_CORE = 3;

    // control register field positions
    localparam int CTL_FLAG_LSB = 0;
    localparam int CTL_EN_LSB   = 3;
    localparam int CTL_GRP_BIT  = 6;
    localparam int CTL_GIE_BIT  = 7;

    localparam int ADDR_CTL       = 0;
    localparam int ADDR_FLAG_BASE = 1;

    typedef enum logic [1:0] {
        GS_DISARMED   = 2'd0,
        GS_ARMED      = 2'd1,
        GS_IN_HANDLER = 2'd2
    } gie_state_e;
endpackage

// File: rtl/irq_core_ctl.sv
module irq_core_ctl
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CORE-1:0] evt,
    input  logic                wr,
    input  logic [NUM_CORE-1:0] flag_wd,
    input  logic [NUM_CORE-1:0] en_wd,
    input  logic                grp_wd,
    output logic [NUM_CORE-1:0] flags,
    output logic [NUM_CORE-1:0] ens,
    output logic                grp_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= '0;
            ens    <= '0;
            grp_en <= 1'b0;
        end else begin
            // event OR-ed in after the write: a set beats a clear
            flags <= (wr ? flag_wd : flags) | evt;
            if (wr) begin
                ens    <= en_wd;
                grp_en <= grp_wd;
            end
        end
    end

    // R2 / R4: any event is visible in the flags one cycle later
    p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_periph_bank.sv
module irq_periph_bank
    import irq_pkg::*;
#(
    parameter int ACTIVE = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic              wr_flag,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] flag_q,
    output logic [DATA_W-1:0] en_q,
    output logic              hit
);
    localparam logic [DATA_W-1:0] MASK = DATA_W'((64'd1 << ACTIVE) - 64'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= ((wr_flag ? wdata : flag_q) | evt) & MASK;
            if (wr_en)
                en_q <= wdata & MASK;
        end
    end

    always_comb hit = |(flag_q & en_q);

    // R3: with no write and no event, flags hold
    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag && (evt & MASK) == '0) |=> $stable(flag_q));
endmodule

// File: rtl/irq_gie_fsm.sv
module irq_gie_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic gie_wd,
    input  logic irq_taken,
    input  logic irq_return,
    output logic gie
);
    gie_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (irq_taken)
            state_d = GS_IN_HANDLER;
        else if (irq_return)
            state_d = GS_ARMED;
        else if (ctl_wr) begin
            unique case (state_q)
                GS_DISARMED:   state_d = gie_wd ? GS_ARMED : GS_DISARMED;
                GS_ARMED:      state_d = gie_wd ? GS_ARMED : GS_DISARMED;
                GS_IN_HANDLER: state_d = gie_wd ? GS_ARMED : GS_IN_HANDLER;
                default:       state_d = GS_DISARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            GS_ARMED: gie = 1'b1;
            default:  gie = 1'b0;
        endcase
    end

    // R7 / R9: taken always ends armed state
    p_taken_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !gie);
    // R8
    p_return_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_taken) |=> gie);
    // R11
    p_write_arms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && gie_wd && !irq_taken) |=> gie);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int NUM_PERIPH = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_CORE+NUM_PERIPH-1:0]        src_evt,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic                                  bus_wr,
    input  logic [DATA_W-1:0]                     bus_wdata,
    output logic [DATA_W-1:0]                     bus_rdata,
    input  logic                                  irq_taken,
    input  logic                                  irq_return,
    output logic                                  irq_req
);
    localparam int NUM_SRC   = NUM_CORE + NUM_PERIPH;
    localparam int NUM_BANKS = (NUM_PERIPH + DATA_W - 1) / DATA_W;
    localparam int EN_BASE   = ADDR_FLAG_BASE + NUM_BANKS;

    logic                 ctl_wr;
    logic [NUM_CORE-1:0]  core_flags, core_ens;
    logic                 grp_en, gie, core_hit;
    logic [NUM_BANKS*DATA_W-1:0] periph_evt;
    logic [DATA_W-1:0]    bflag [NUM_BANKS];
    logic [DATA_W-1:0]    ben   [NUM_BANKS];
    logic [NUM_BANKS-1:0] bhit;

    always_comb ctl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTL));

    always_comb begin
        periph_evt = '0;
        periph_evt[NUM_PERIPH-1:0] = src_evt[NUM_SRC-1:NUM_CORE];
    end

    irq_core_ctl u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (src_evt[NUM_CORE-1:0]),
        .wr      (ctl_wr),
        .flag_wd (bus_wdata[CTL_FLAG_LSB +: NUM_CORE]),
        .en_wd   (bus_wdata[CTL_EN_LSB +: NUM_CORE]),
        .grp_wd  (bus_wdata[CTL_GRP_BIT]),
        .flags   (core_flags),
        .ens     (core_ens),
        .grp_en  (grp_en)
    );

    irq_gie_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .gie_wd     (bus_wdata[CTL_GIE_BIT]),
        .irq_taken  (irq_taken),
        .irq_return (irq_return),
        .gie        (gie)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int REMAIN = NUM_PERIPH - b * DATA_W;
        localparam int ACT    = (REMAIN >= DATA_W) ? DATA_W : REMAIN;
        logic wr_f, wr_e;
        always_comb begin
            wr_f = bus_wr && (bus_addr == ADDR_W'(ADDR_FLAG_BASE + b));
            wr_e = bus_wr && (bus_addr == ADDR_W'(EN_BASE + b));
        end
        irq_periph_bank #(.ACTIVE(ACT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (periph_evt[b*DATA_W +: DATA_W]),
            .wr_flag (wr_f),
            .wr_en   (wr_e),
            .wdata   (bus_wdata),
            .flag_q  (bflag[b]),
            .en_q    (ben[b]),
            .hit     (bhit[b])
        );
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTL)) begin
            bus_rdata[CTL_FLAG_LSB +: NUM_CORE] = core_flags;
            bus_rdata[CTL_EN_LSB +: NUM_CORE]   = core_ens;
            bus_rdata[CTL_GRP_BIT]              = grp_en;
            bus_rdata[CTL_GIE_BIT]              = gie;
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(ADDR_FLAG_BASE + b)) bus_rdata = bflag[b];
            if (bus_addr == ADDR_W'(EN_BASE + b))        bus_rdata = ben[b];
        end
    end

    // output process: two-tier gating
    always_comb begin
        core_hit = |(core_flags & core_ens);
        irq_req  = gie && (core_hit || (grp_en && (|bhit)));
    end

    // R7: request is gone the cycle after the processor takes it
    p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !irq_req);
    // R6: a request without a core hit needs the group enable
    p_periph_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !core_hit) |-> (grp_en && (bhit != '0)));
    // R5: a request always has an armed global enable
    p_req_needs_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] src_evt = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_taken = 1'b0;
    logic        irq_return = 1'b0;
    logic        irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (src_evt),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_taken  (irq_taken),
        .irq_return (irq_return),
        .irq_req    (irq_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic req_check(input string req, input logic exp);
        @(negedge clk);
        check(req, {7'd0, irq_req}, {7'd0, exp});
    endtask

    task automatic pulse_src(input logic [14:0] m);
        @(negedge clk);
        src_evt = m;
        @(posedge clk); #1;
        src_evt = '0;
    endtask

    task automatic pulse_proc(input logic tk, input logic rt);
        @(negedge clk);
        irq_taken = tk; irq_return = rt;
        @(posedge clk); #1;
        irq_taken = 1'b0; irq_return = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 5; a++) rd_check("R1 reset", 3'(a), 8'h00);
        req_check("R1 req", 1'b0);
    endtask

    task automatic t_poll_disabled;
        pulse_src(15'h4009);            // core 0, periph 0, periph 11
        rd_check("R2 core flag", 3'd0, 8'h01);
        rd_check("R2 bank0 flag", 3'd1, 8'h01);
        rd_check("R2 bank1 flag", 3'd2, 8'h08);
        req_check("R2 no req", 1'b0);
    endtask

    task automatic t_clear;
        wr(3'd0, 8'h00);
        rd_check("R3 core clear", 3'd0, 8'h00);
        wr(3'd1, 8'h00);
        rd_check("R3 bank0 clear", 3'd1, 8'h00);
        wr(3'd2, 8'h05);
        rd_check("R3 software set", 3'd2, 8'h05);
        wr(3'd2, 8'h00);
        rd_check("R3 bank1 clear", 3'd2, 8'h00);
    endtask

    task automatic t_collision;
        @(negedge clk);
        src_evt = 15'h0002; bus_addr = 3'd0; bus_wr = 1'b1; bus_wdata = 8'h00;
        @(posedge clk); #1;
        src_evt = '0; bus_wr = 1'b0;
        rd_check("R4 set wins", 3'd0, 8'h02);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_core;
        wr(3'd0, 8'h90);
        req_check("R5 no flag", 1'b0);
        pulse_src(15'h0002);
        req_check("R5 core req", 1'b1);
        wr(3'd0, 8'h12);
        req_check("R11 disarm req", 1'b0);
        rd_check("R11 disarm read", 3'd0, 8'h12);
        wr(3'd0, 8'h92);
        req_check("R11 rearm req", 1'b1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_periph;
        pulse_src(15'h0020);            // periph 2, bank0 bit2
        wr(3'd3, 8'h04);
        wr(3'd0, 8'h80);
        req_check("R6 group off", 1'b0);
        wr(3'd0, 8'hC0);
        req_check("R6 group on", 1'b1);
        wr(3'd3, 8'h00);
        req_check("R6 own enable off", 1'b0);
        wr(3'd1, 8'h00);
        pulse_src(15'h2000);            // periph 10, bank1 bit2
        wr(3'd4, 8'h04);
        req_check("R6 bank1 req", 1'b1);
        wr(3'd0, 8'h40);
        req_check("R6 gie off", 1'b0);
        wr(3'd4, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_taken_return;
        wr(3'd0, 8'h89);
        req_check("R5 core0 req", 1'b1);
        pulse_proc(1'b1, 1'b0);
        check("R7 req drops", {7'd0, irq_req}, 8'h00);
        rd_check("R7 flags kept", 3'd0, 8'h09);
        pulse_proc(1'b0, 1'b1);
        check("R8 req back", {7'd0, irq_req}, 8'h01);
        rd_check("R8 gie set", 3'd0, 8'h89);
    endtask

    task automatic t_simul;
        pulse_proc(1'b1, 1'b1);
        rd_check("R9 taken wins", 3'd0, 8'h09);
        req_check("R9 req low", 1'b0);
        pulse_proc(1'b0, 1'b1);
        req_check("R8 return alone", 1'b1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_map;
        wr(3'd2, 8'hFF);
        rd_check("R10 bank1 flag mask", 3'd2, 8'h0F);
        wr(3'd4, 8'hFF);
        rd_check("R10 bank1 en mask", 3'd4, 8'h0F);
        wr(3'd2, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'hFF);
        rd_check("R10 addr5 reads 0", 3'd5, 8'h00);
        for (int a = 0; a < 5; a++) rd_check("R10 addr5 write ignored", 3'(a), 8'h00);
        req_check("R10 no req", 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_poll_disabled();
        t_clear();
        t_collision();
        t_core();
        t_periph();
        t_taken_return();
        t_simul();
        t_map();
        finish_run();
    end

    initial begin
        #(1_000_000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule